// File: doc/BRIEF.md
# Card Response Capture FIFO

This block listens on the serial command line of a memory card after a command has gone out, recognises the start bit of the card's reply and shifts in the reply bits on each card-clock tick. It checks the 7-bit CRC when the response type calls for it and hands the captured reply to software as a short queue of 16-bit halfwords. Three status flags report the result: the response finished, the CRC did not match, and the card never answered.

A 2-bit response-kind code picks the reply length and the checking rule. A separate long-disable input turns off long-response handling. A programmable limit sets how many card-clock ticks the block waits for a start bit. Software reads the reply by popping halfwords. A short reply gives three halfwords, and the 32-bit card status spans the low byte of the first, all of the second and the high byte of the third. A long reply gives eight halfwords, most significant first.

Top module: `rsp_capture`

## Requirements
- R1: After reset, resp_cnt is 0, rd_data is 0, busy is 0 and all three status flags are 0.
- R2: resp_kind 1 captures a 48-bit frame and loads three halfwords: bits [47:32], then [31:16], then [15:0] of the frame as received, first bit most significant.
- R3: resp_kind 2 with long_off low captures a 136-bit frame and loads eight halfwords holding frame bits [127:0], most significant halfword first. The 8 header bits are dropped.
- R4: CRC-7 (x^7+x^3+1, zero start value) covers frame bits [47:8] of a short frame and bits [127:8] of a long frame. For resp_kind 1 and 2, stat_crc_err is set if the computed value differs from frame bits [7:1]. The end bit is not checked.
- R5: resp_kind 3 captures 48 bits exactly like kind 1 but never sets stat_crc_err.
- R6: resp_kind 0 does not wait on the line. It sets stat_end within two clocks of cmd_go and leaves resp_cnt at 0.
- R7: With tmo_limit N (N at least 1), if N consecutive ticks see the line high while a start bit is awaited, stat_timeout and stat_end are set and resp_cnt stays 0. A start bit on tick N or earlier avoids the timeout.
- R8: A pop with resp_cnt 0 leaves resp_cnt at 0, and rd_data reads 0 while the queue is empty.
- R9: Each pop with resp_cnt nonzero advances to the next halfword and lowers resp_cnt by one.
- R10: With long_off high, resp_kind 2 is handled as a 48-bit frame with a CRC check.
- R11: cmd_go while idle clears all status flags and empties the queue on the next clock, and busy is high until the result is posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_tick | input | 1 | One-cycle enable marking a card-clock sampling point |
| cmd_line | input | 1 | Serial command line from the card, idle high |
| cmd_go | input | 1 | Pulse: command sent, begin awaiting the reply |
| resp_kind | input | 2 | 0 none, 1 48-bit with CRC, 2 136-bit, 3 48-bit without CRC |
| long_off | input | 1 | Treat kind 2 as a 48-bit reply with CRC |
| tmo_limit | input | TMO_W | Card-clock ticks to wait for a start bit |
| rd_pop | input | 1 | Pop the halfword at the head of the queue |
| rd_data | output | 16 | Head halfword, 0 when empty |
| resp_cnt | output | 4 | Halfwords left in the queue |
| busy | output | 1 | A reply is being awaited or captured |
| stat_end | output | 1 | Response phase finished |
| stat_crc_err | output | 1 | CRC mismatch on a checked reply |
| stat_timeout | output | 1 | No start bit within the limit |

## Verification
The bench sends random short and long frames, with and without a corrupted CRC. A mistake in the CRC polynomial or its bit range would flag good frames or pass bad ones, and a misplaced halfword split would scramble the card status across the three reads. It places the start bit on exactly the last allowed tick and then lets one more idle tick pass, so an off-by-one timeout counter is exposed in one direction or the other. It also pops an empty queue, sends a no-CRC frame with a bad CRC and sends a long-kind command with long_off set. A design that wraps its read pointer, checks CRC on kind 3, or waits for 136 bits would fail these checks.

// File: rtl/rsp_cap_pkg.sv
// Package: shared constants and types for the response capture block.
// Assumes the frame formats of card command responses: 48 or 136 bits,
// transmitted most significant bit first, starting with a zero start bit.
package rsp_cap_pkg;
    localparam int HW_W       = 16;
    localparam int FIFO_D     = 8;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int SR_W       = 128;
    localparam int CNT_W      = 8;
    localparam int SHORT_HW   = SHORT_BITS / HW_W;
    localparam int LONG_HW    = SR_W / HW_W;
    localparam int CRC_W      = 7;
    localparam int SHORT_CRC_LO = 1;
    localparam int SHORT_CRC_HI = SHORT_BITS - CRC_W - 2;
    localparam int LONG_CRC_LO  = 8;
    localparam int LONG_CRC_HI  = LONG_BITS - CRC_W - 2;

    typedef enum logic [1:0] {
        MODE_NONE, MODE_SHORT_CRC, MODE_SHORT_RAW, MODE_LONG
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_WAIT, ST_SHIFT, ST_FIN
    } st_e;

    // Map the 2-bit response-kind code and the long-disable bit to a mode.
    function automatic mode_e decode_kind(input logic [1:0] kind, input logic long_off);
        case (kind)
            2'd1:    return MODE_SHORT_CRC;
            2'd2:    return long_off ? MODE_SHORT_CRC : MODE_LONG;
            2'd3:    return MODE_SHORT_RAW;
            default: return MODE_NONE;
        endcase
    endfunction
endpackage

// File: rtl/rsp_crc7.sv
// Serial CRC-7 generator, polynomial x^7+x^3+1, zero start value.
// Assumes one bit per enabled cycle, most significant bit of the frame first.
module rsp_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);
    logic fb;
    assign fb = din ^ crc[6];

    // Shift one bit into the CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= {crc[5:3], crc[2] ^ fb, crc[1:0], fb};
        end
    end
endmodule

// File: rtl/rsp_frame_rx.sv
// Frame receiver: waits for the start bit under a tick limit, then shifts the
// reply into a register and steers the CRC generator over the covered bits.
// Assumes cmd_line is already synchronous to clk and sampled only on ticks.
module rsp_frame_rx
    import rsp_cap_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic             go,
    input  mode_e            mode_in,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             busy,
    output logic             fin,
    output mode_e            mode,
    output logic             tmo_hit,
    output logic [SR_W-1:0]  sr,
    output logic             crc_clr,
    output logic             crc_en,
    output logic             crc_din
);
    st_e               st;
    logic [CNT_W-1:0]  idx;
    logic [TMO_W-1:0]  wcnt;
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  crc_lo;
    logic [CNT_W-1:0]  crc_hi;
    logic              wait_over;

    // Frame length and CRC coverage for the latched mode.
    always_comb begin
        if (mode == MODE_LONG) begin
            last_idx = CNT_W'(LONG_BITS - 1);
            crc_lo   = CNT_W'(LONG_CRC_LO);
            crc_hi   = CNT_W'(LONG_CRC_HI);
        end else begin
            last_idx = CNT_W'(SHORT_BITS - 1);
            crc_lo   = CNT_W'(SHORT_CRC_LO);
            crc_hi   = CNT_W'(SHORT_CRC_HI);
        end
    end

    assign wait_over = ({1'b0, wcnt} + 1'b1) >= {1'b0, tmo_limit};
    assign tmo_hit   = (st == ST_WAIT) && tick && line && wait_over;
    assign fin       = (st == ST_FIN);
    assign busy      = (st != ST_IDLE);
    assign crc_clr   = (st == ST_IDLE) && go;
    assign crc_en    = (st == ST_SHIFT) && tick && (idx >= crc_lo) && (idx <= crc_hi);
    assign crc_din   = line;

    // Sequence through wait, shift and finish for one reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            mode <= MODE_NONE;
            idx  <= '0;
            wcnt <= '0;
            sr   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    mode <= mode_in;
                    idx  <= '0;
                    wcnt <= '0;
                    sr   <= '0;
                    st   <= (mode_in == MODE_NONE) ? ST_FIN : ST_WAIT;
                end
                ST_WAIT: if (tick) begin
                    if (!line) begin
                        sr  <= {sr[SR_W-2:0], 1'b0};
                        idx <= CNT_W'(1);
                        st  <= ST_SHIFT;
                    end else if (wait_over) begin
                        st <= ST_IDLE;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_SHIFT: if (tick) begin
                    sr <= {sr[SR_W-2:0], line};
                    if (idx == last_idx) st <= ST_FIN;
                    else idx <= idx + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rsp_fifo.sv
// Halfword queue: loaded in parallel with a whole reply, drained one entry
// per pop. Entry i of a load is ld_data[top-16*i -: 16].
// Assumes a load never exceeds the depth; flush has priority over load.
module rsp_fifo
    import rsp_cap_pkg::*;
#(
    parameter int DEPTH = FIFO_D,
    parameter int W     = HW_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        ld,
    input  logic [$clog2(DEPTH+1)-1:0]  ld_cnt,
    input  logic [DEPTH*W-1:0]          ld_data,
    input  logic                        pop,
    output logic [W-1:0]                rd_data,
    output logic [$clog2(DEPTH+1)-1:0]  cnt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [W-1:0]     ent [DEPTH];
    logic [PTR_W-1:0] rptr;

    // One storage register per entry, written only on a load.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) ent[i] <= '0;
            else if (ld && !flush) ent[i] <= ld_data[DEPTH*W-1-i*W -: W];
        end
    end

    // Track read position and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rptr <= '0;
            cnt  <= '0;
        end else if (ld) begin
            rptr <= '0;
            cnt  <= ld_cnt;
        end else if (pop && cnt != '0) begin
            rptr <= rptr + 1'b1;
            cnt  <= cnt - LVL_W'(1);
        end
    end

    assign rd_data = (cnt != '0) ? ent[rptr] : '0;
endmodule

// File: rtl/rsp_capture.sv
// Top: command response capture with CRC check, timeout and halfword queue.
// Assumes cmd_go arrives only after the command has left the host; a go
// while busy is ignored.
module rsp_capture
    import rsp_cap_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_tick,
    input  logic             cmd_line,
    input  logic             cmd_go,
    input  logic [1:0]       resp_kind,
    input  logic             long_off,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             rd_pop,
    output logic [15:0]      rd_data,
    output logic [3:0]       resp_cnt,
    output logic             busy,
    output logic             stat_end,
    output logic             stat_crc_err,
    output logic             stat_timeout
);
    localparam int LVL_W = $clog2(FIFO_D+1);

    mode_e             mode;
    logic              fin, tmo_hit, crc_clr, crc_en, crc_din;
    logic [SR_W-1:0]   sr;
    logic [6:0]        crc;
    logic              start;
    logic              ld;
    logic [LVL_W-1:0]  ld_cnt;
    logic [SR_W-1:0]   ld_data;
    logic              crc_bad;

    assign start = cmd_go && !busy;

    rsp_frame_rx #(.TMO_W(TMO_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(card_tick), .line(cmd_line),
        .go(cmd_go), .mode_in(decode_kind(resp_kind, long_off)),
        .tmo_limit(tmo_limit), .busy(busy), .fin(fin), .mode(mode),
        .tmo_hit(tmo_hit), .sr(sr), .crc_clr(crc_clr), .crc_en(crc_en),
        .crc_din(crc_din)
    );

    rsp_crc7 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(crc_din), .crc(crc)
    );

    // Select what the finished reply loads into the queue.
    always_comb begin
        ld = fin && (mode != MODE_NONE);
        if (mode == MODE_LONG) begin
            ld_cnt  = LVL_W'(LONG_HW);
            ld_data = sr;
        end else begin
            ld_cnt  = LVL_W'(SHORT_HW);
            ld_data = {sr[SHORT_BITS-1:0], {(SR_W-SHORT_BITS){1'b0}}};
        end
        crc_bad = (mode == MODE_SHORT_CRC || mode == MODE_LONG) && (crc != sr[7:1]);
    end

    rsp_fifo #(.DEPTH(FIFO_D), .W(HW_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(start), .ld(ld), .ld_cnt(ld_cnt),
        .ld_data(ld_data), .pop(rd_pop), .rd_data(rd_data), .cnt(resp_cnt)
    );

    // Sticky status flags, cleared when a new command starts.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            stat_end     <= 1'b0;
            stat_crc_err <= 1'b0;
            stat_timeout <= 1'b0;
        end else begin
            if (tmo_hit) begin
                stat_end     <= 1'b1;
                stat_timeout <= 1'b1;
            end
            if (fin) begin
                stat_end <= 1'b1;
                if (crc_bad) stat_crc_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsp_capture_chk.sv
// Checker: port-level properties of the response capture block.
module rsp_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_go,
    input logic        rd_pop,
    input logic [15:0] rd_data,
    input logic [3:0]  resp_cnt,
    input logic        busy,
    input logic        stat_end,
    input logic        stat_crc_err,
    input logic        stat_timeout
);
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        resp_cnt == 4'd0 |-> rd_data == 16'd0); // R8
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && resp_cnt == 4'd0 && !busy && !cmd_go) |=> resp_cnt == 4'd0); // R8
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && resp_cnt != 4'd0 && !busy && !cmd_go) |=> resp_cnt == $past(resp_cnt) - 4'd1); // R9
    AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        resp_cnt <= 4'd8); // R3
    AST_GO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !busy) |=> (busy && !stat_end && resp_cnt == 4'd0)); // R11
    AST_TMO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_timeout |-> (stat_end && resp_cnt == 4'd0 && !stat_crc_err)); // R7
    AST_CRC_END: assert property (@(posedge clk) disable iff (!rst_n)
        stat_crc_err |-> stat_end); // R4
    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_end) |-> !busy); // R11
endmodule

bind rsp_capture rsp_capture_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .rd_pop(rd_pop),
    .rd_data(rd_data), .resp_cnt(resp_cnt), .busy(busy),
    .stat_end(stat_end), .stat_crc_err(stat_crc_err),
    .stat_timeout(stat_timeout)
);

// File: tb/rsp_capture_test.sv
module rsp_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_tick = 1'b0;
    logic        cmd_line = 1'b1;
    logic        cmd_go = 1'b0;
    logic [1:0]  resp_kind = 2'd0;
    logic        long_off = 1'b0;
    logic [7:0]  tmo_limit = 8'hFF;
    logic        rd_pop = 1'b0;
    logic [15:0] rd_data;
    logic [3:0]  resp_cnt;
    logic        busy, stat_end, stat_crc_err, stat_timeout;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rsp_capture uut (
        .clk(clk), .rst_n(rst_n), .card_tick(card_tick), .cmd_line(cmd_line),
        .cmd_go(cmd_go), .resp_kind(resp_kind), .long_off(long_off),
        .tmo_limit(tmo_limit), .rd_pop(rd_pop), .rd_data(rd_data),
        .resp_cnt(resp_cnt), .busy(busy), .stat_end(stat_end),
        .stat_crc_err(stat_crc_err), .stat_timeout(stat_timeout)
    );

    function automatic logic [6:0] crc7(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c = '0;
        for (int i = hi; i >= lo; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [135:0] mk_short(input logic [5:0] ix, input logic [31:0] st, input bit corrupt);
        logic [135:0] f = '0;
        f[47:8] = {2'b00, ix, st};
        f[7:1]  = crc7(f, 47, 8) ^ (corrupt ? 7'h01 : 7'h00);
        f[0]    = 1'b1;
        return f;
    endfunction

    function automatic logic [135:0] mk_long(input logic [119:0] pl, input bit corrupt);
        logic [135:0] f = '0;
        f[135:8] = {2'b00, 6'h3F, pl};
        f[7:1]   = crc7(f, 127, 8) ^ (corrupt ? 7'h01 : 7'h00);
        f[0]     = 1'b1;
        return f;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_bit(input logic b);
        @(negedge clk);
        cmd_line  = b;
        card_tick = 1'b1;
        @(negedge clk);
        card_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_cmd(input logic [1:0] k, input logic lo, input logic [7:0] tl);
        @(negedge clk);
        resp_kind = k;
        long_off  = lo;
        tmo_limit = tl;
        cmd_go    = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic send(input logic [135:0] f, input int n);
        for (int i = n - 1; i >= 0; i--) tick_bit(f[i]);
        cmd_line = 1'b1;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20 && !stat_end; i++) @(negedge clk);
    endtask

    task automatic pop_hw(output logic [15:0] v);
        @(negedge clk);
        rd_pop = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    // Run one reply and compare flags and readback with the model.
    task automatic run_frame(input string req, input logic [1:0] k, input logic lo,
                             input logic [135:0] f, input bit exp_err);
        logic [15:0] v;
        int nb, nh, top;
        bit longf;
        longf = (k == 2'd2) && !lo;
        nb  = longf ? 136 : 48;
        nh  = longf ? 8 : 3;
        top = longf ? 127 : 47;
        start_cmd(k, lo, 8'd20);
        tick_bit(1'b1);
        send(f, nb);
        wait_end();
        @(negedge clk);
        check({req, " end"}, stat_end, 1);
        check({req, " crc"}, stat_crc_err, exp_err);
        check({req, " tmo"}, stat_timeout, 0);
        check({req, " cnt"}, resp_cnt, nh);
        for (int i = 0; i < nh; i++) begin
            pop_hw(v);
            check({req, " data"}, v, f[top - 16*i -: 16]);
        end
        check("R9 drained", resp_cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cnt", resp_cnt, 0);
        check("R1 data", rd_data, 0);
        check("R1 busy", busy, 0);
        check("R1 flags", {stat_end, stat_crc_err, stat_timeout}, 0);

        // R8 pop while empty
        pop_hw(v);
        check("R8 empty data", v, 0);
        check("R8 empty cnt", resp_cnt, 0);

        // R2, R3, R4, R5, R10 directed frames
        run_frame("R2 short", 2'd1, 1'b0, mk_short(6'd17, 32'hA1B2C3D4, 0), 0);
        run_frame("R3 long", 2'd2, 1'b0, mk_long(120'h0123456789ABCDEF0011223344556, 0), 0);
        run_frame("R4 short bad", 2'd1, 1'b0, mk_short(6'd3, 32'h00000900, 1), 1);
        run_frame("R4 long bad", 2'd2, 1'b0, mk_long(120'hFEDCBA98765432100FF00FF00FF0, 1), 1);
        run_frame("R5 raw bad", 2'd3, 1'b0, mk_short(6'h3F, 32'h80FF0000, 1), 0);
        run_frame("R10 long off", 2'd2, 1'b1, mk_short(6'd9, 32'h12345678, 0), 0);
        run_frame("R10 long off bad", 2'd2, 1'b1, mk_short(6'd9, 32'h12345678, 1), 1);

        // R11 go clears flags and queue left from previous reply
        run_frame("R11 prep", 2'd1, 1'b0, mk_short(6'd1, 32'h1, 1), 1);
        start_cmd(2'd1, 1'b0, 8'd20);
        #1;
        check("R11 busy", busy, 1);
        check("R11 cleared", {stat_end, stat_crc_err, resp_cnt}, 0);
        send(mk_short(6'd2, 32'h2, 0), 48);
        wait_end();
        @(negedge clk);
        check("R11 end", stat_end, 1);

        // R6 no-response kind
        start_cmd(2'd0, 1'b0, 8'd20);
        @(negedge clk);
        check("R6 end", stat_end, 1);
        check("R6 cnt", resp_cnt, 0);
        check("R6 busy", busy, 0);

        // R7 timeout after exactly N idle ticks
        start_cmd(2'd1, 1'b0, 8'd5);
        repeat (4) tick_bit(1'b1);
        check("R7 no early tmo", stat_timeout, 0);
        tick_bit(1'b1);
        check("R7 tmo", stat_timeout, 1);
        check("R7 end", stat_end, 1);
        check("R7 cnt", resp_cnt, 0);
        check("R7 idle", busy, 0);

        // R7 start bit on the last allowed tick
        start_cmd(2'd1, 1'b0, 8'd5);
        repeat (4) tick_bit(1'b1);
        begin
            logic [135:0] f = mk_short(6'd5, 32'hCAFEF00D, 0);
            send(f, 48);
            wait_end();
            @(negedge clk);
            check("R7 late start tmo", stat_timeout, 0);
            check("R7 late start crc", stat_crc_err, 0);
            check("R7 late start cnt", resp_cnt, 3);
            pop_hw(v);
            check("R9 first", v, f[47:32]);
            check("R9 step", resp_cnt, 2);
        end

        // Random mix
        for (int n = 0; n < 24; n++) begin
            logic [1:0] k = 2'($urandom_range(1, 3));
            logic lo = 1'($urandom_range(0, 1));
            bit corrupt = 1'($urandom_range(0, 1));
            bit longf = (k == 2'd2) && !lo;
            logic [135:0] f;
            if (longf) f = mk_long({$urandom, $urandom, $urandom, $urandom} >> 8, corrupt);
            else f = mk_short(6'($urandom), $urandom, corrupt);
            run_frame("R4 random", k, lo, f, corrupt && (k != 2'd3));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule